// File: doc/BRIEF.md
# Fetch Block Mask and Next-Address Selector

This block decides, once per fetch access, which of the sixteen instruction slots in a fetch block are valid and where the next fetch should start. A fetch block is two back-to-back instruction cache lines of eight slots each, so a full fetch width is available even when the fetch address points into the middle of the first line. The block does not hold the cache arrays, the branch target buffer storage or the predictor tables. It receives the line hit flags, one branch target buffer record per slot (valid bit, transfer kind, target), three ordered direction predictions and the top of the return stack.

Starting at the slot the fetch address points to, the block walks forward and keeps each instruction up to and including the first taken control transfer. The first three conditional branches use the three predictions in order. Jumps and calls are always taken to their buffer target. Returns are always taken to the return-stack top. A fourth conditional branch cannot be predicted in the same access, so the block stops just before it. If either line misses, the block reports a stall and the fetch address is presented again. Results are registered and appear one clock after the inputs are sampled.

Top module: `fetch_block_sel`

## Requirements
- R1: Outputs are registered: the mask, next address and stall seen after clock edge k are computed from the inputs sampled at edge k.
- R2: If either bit of `line_hit` is 0, then `stall_o`=1, `inst_mask_o`=0 and `next_pc_o` equals the sampled `fetch_addr`.
- R3: Slots below the fetch offset (`fetch_addr[4:2]` with the default parameters) are never valid, and buffer records in those slots have no effect.
- R4: Slots without a valid buffer record are ordinary instructions, whatever their kind field holds. If no transfer is taken and the block is not cut, `next_pc_o` = `fetch_addr` + 4 × (number of valid slots).
- R5: Conditional branches (kind 2'b00) take their directions from `pred_taken[0]`, `pred_taken[1]`, `pred_taken[2]` in slot order. A not-taken branch stays valid and the walk continues.
- R6: A taken conditional branch is the last valid slot, and `next_pc_o` is its buffer target. The mask is always one unbroken run of ones.
- R7: Jumps (kind 2'b01) and calls (kind 2'b10) are always taken. Each is the last valid slot, and `next_pc_o` is its buffer target.
- R8: A return (kind 2'b11) is always taken. It is the last valid slot, and `next_pc_o` is `ras_top`.
- R9: A fourth conditional branch reached with no taken transfer ends the block before it: that slot is not valid, and `next_pc_o` is its own address (line-aligned base + 4 × slot).
- R10: While reset is held, `inst_mask_o`=0, `stall_o`=0 and `next_pc_o`=`RESET_PC`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_addr | input | ADDR_W | Address of the first instruction to fetch |
| line_hit | input | 2 | Hit flags for the first and second line |
| btb_valid | input | 16 | Per-slot branch record present |
| btb_kind | input | 32 | Per-slot transfer kind, 2 bits per slot |
| btb_target | input | 16*ADDR_W | Per-slot target address |
| pred_taken | input | 3 | Ordered direction predictions |
| ras_top | input | ADDR_W | Return-stack top |
| inst_mask_o | output | 16 | Valid-instruction mask, bit i is slot i |
| next_pc_o | output | ADDR_W | Next fetch address |
| stall_o | output | 1 | Line miss, fetch must be retried |

## Verification
The hardest case to reach from the ports is the cut at a fourth conditional branch. It needs three not-taken predictions, three earlier conditional records at or after the fetch offset, and no other transfer ahead of the fourth. Random stimulus almost never lines all of that up. Directed steps therefore place four conditional records after a nonzero offset with all predictions clear, and they also place one such record below the offset to show it is not counted. Each step is checked against a behavioural model in the bench.

// File: rtl/fetch_block_sel.sv
module fetch_block_sel #(
  parameter int ADDR_W      = 32,
  parameter int LINE_SLOTS  = 8,
  parameter int INSTR_BYTES = 4,
  parameter int NPRED       = 3,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             fetch_addr,
  input  logic [1:0]                    line_hit,
  input  logic [2*LINE_SLOTS-1:0]       btb_valid,
  input  logic [4*LINE_SLOTS-1:0]       btb_kind,
  input  logic [2*LINE_SLOTS*ADDR_W-1:0] btb_target,
  input  logic [NPRED-1:0]              pred_taken,
  input  logic [ADDR_W-1:0]             ras_top,
  output logic [2*LINE_SLOTS-1:0]       inst_mask_o,
  output logic [ADDR_W-1:0]             next_pc_o,
  output logic                          stall_o
);
  localparam int SLOTS = 2 * LINE_SLOTS;
  localparam int OFF_W = $clog2(LINE_SLOTS);
  localparam int IB_W  = $clog2(INSTR_BYTES);
  localparam int CNT_W = $clog2(SLOTS + 1);
  localparam int NC_W  = $clog2(NPRED + 1);
  localparam logic [1:0] K_COND = 2'b00, K_JUMP = 2'b01, K_CALL = 2'b10, K_RET = 2'b11;

  logic [OFF_W-1:0]  off;
  logic [ADDR_W-1:0] base;
  assign off  = fetch_addr[IB_W +: OFF_W];
  assign base = {fetch_addr[ADDR_W-1:OFF_W+IB_W], {(OFF_W+IB_W){1'b0}}};

  logic [SLOTS-1:0]  mask_c;
  logic [ADDR_W-1:0] next_c;
  logic              done;
  logic [NC_W-1:0]   nc;
  logic [CNT_W-1:0]  cnt;

  always_comb begin
    mask_c = '0;
    next_c = '0;
    done   = 1'b0;
    nc     = '0;
    cnt    = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (!done && i >= int'(off)) begin
        if (btb_valid[i]) begin
          unique case (btb_kind[2*i +: 2])
            K_COND: begin
              if (nc == NC_W'(NPRED)) begin
                done   = 1'b1;
                next_c = base + (ADDR_W'(i) << IB_W);
              end else begin
                mask_c[i] = 1'b1;
                cnt       = cnt + CNT_W'(1);
                if (pred_taken[nc]) begin
                  done   = 1'b1;
                  next_c = btb_target[i*ADDR_W +: ADDR_W];
                end
                nc = nc + NC_W'(1);
              end
            end
            K_JUMP, K_CALL: begin
              mask_c[i] = 1'b1;
              cnt       = cnt + CNT_W'(1);
              done      = 1'b1;
              next_c    = btb_target[i*ADDR_W +: ADDR_W];
            end
            default: begin
              mask_c[i] = 1'b1;
              cnt       = cnt + CNT_W'(1);
              done      = 1'b1;
              next_c    = ras_top;
            end
          endcase
        end else begin
          mask_c[i] = 1'b1;
          cnt       = cnt + CNT_W'(1);
        end
      end
    end
    if (!done) next_c = fetch_addr + (ADDR_W'(cnt) << IB_W);
  end

  wire miss = ~&line_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inst_mask_o <= '0;
      next_pc_o   <= RESET_PC;
      stall_o     <= 1'b0;
    end else begin
      inst_mask_o <= miss ? '0 : mask_c;
      next_pc_o   <= miss ? fetch_addr : next_c;
      stall_o     <= miss;
    end
  end

  p_stall_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> inst_mask_o == '0);
  p_stall_retry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> next_pc_o == $past(fetch_addr));
  p_below_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !stall_o |-> (inst_mask_o & ((SLOTS'(1) << $past(off)) - SLOTS'(1))) == '0);
  p_single_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(inst_mask_o & ~(inst_mask_o << 1)));
endmodule

// File: tb/fetch_block_sel_bench.sv
`timescale 1ns/1ps
module fetch_block_sel_bench;
  localparam logic [31:0] RPC = 32'h0000_1000;
  logic clk = 0, rst_n = 0;
  logic [31:0] fetch_addr = 0, ras_top = 0;
  logic [1:0] line_hit = 2'b11;
  logic [15:0] btb_valid = 0;
  logic [31:0] btb_kind = 0;
  logic [16*32-1:0] btb_target = 0;
  logic [2:0] pred_taken = 0;
  logic [15:0] inst_mask_o;
  logic [31:0] next_pc_o;
  logic stall_o;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  fetch_block_sel #(.RESET_PC(RPC)) u_fetch_block_sel (
    .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .line_hit(line_hit),
    .btb_valid(btb_valid), .btb_kind(btb_kind), .btb_target(btb_target),
    .pred_taken(pred_taken), .ras_top(ras_top),
    .inst_mask_o(inst_mask_o), .next_pc_o(next_pc_o), .stall_o(stall_o));

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // behavioural reference: walk slot addresses, count conditionals seen
  task automatic model(output logic [15:0] m, output logic [31:0] nx, output logic st);
    integer start, slot, conds;
    bit ended;
    m = 0; st = 0; ended = 0; conds = 0;
    if (line_hit != 2'b11) begin st = 1; nx = fetch_addr; return; end
    start = (fetch_addr / 4) % 8;
    nx = 0;
    slot = start;
    while (slot < 16 && !ended) begin
      if (!btb_valid[slot]) m[slot] = 1;
      else begin
        case (btb_kind[2*slot +: 2])
          2'd0: if (conds == 3) begin
                  ended = 1; nx = (fetch_addr / 32) * 32 + 4 * slot;
                end else begin
                  m[slot] = 1;
                  if (pred_taken[conds]) begin ended = 1; nx = btb_target[32*slot +: 32]; end
                  conds++;
                end
          2'd3: begin m[slot] = 1; ended = 1; nx = ras_top; end
          default: begin m[slot] = 1; ended = 1; nx = btb_target[32*slot +: 32]; end
        endcase
      end
      slot++;
    end
    if (!ended) nx = fetch_addr + 4 * $countones(m);
  endtask

  task automatic step(string tag);
    logic [15:0] em; logic [31:0] en; logic es;
    model(em, en, es);
    @(posedge clk); @(negedge clk);
    chk(tag, "mask", {16'h0, inst_mask_o}, {16'h0, em});
    chk(tag, "next", next_pc_o, en);
    chk(tag, "stall", {31'h0, stall_o}, {31'h0, es});
  endtask

  task automatic clear();
    btb_valid = 0; btb_kind = 0; pred_taken = 0; line_hit = 2'b11;
    for (int i = 0; i < 16; i++) btb_target[32*i +: 32] = 32'h8000_0000 + 32'h100 * i;
  endtask

  task automatic setb(int s, logic [1:0] k);
    btb_valid[s] = 1; btb_kind[2*s +: 2] = k;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    clear();
    fetch_addr = 32'h40;
    repeat (2) @(negedge clk);
    chk("R10", "mask", {16'h0, inst_mask_o}, 32'h0);
    chk("R10", "next", next_pc_o, RPC);
    chk("R10", "stall", {31'h0, stall_o}, 32'h0);
    rst_n = 1;

    fetch_addr = 32'h200; step("R4");
    fetch_addr = 32'h214; step("R3");
    clear(); fetch_addr = 32'h214; setb(2, 2'd1); step("R3");
    clear(); fetch_addr = 32'h300; btb_kind[2*4 +: 2] = 2'd1; step("R4");
    clear(); fetch_addr = 32'h300; setb(3, 2'd0); setb(6, 2'd0); pred_taken = 3'b010; step("R5");
    clear(); fetch_addr = 32'h300; setb(3, 2'd0); setb(6, 2'd0); setb(9, 2'd0);
    pred_taken = 3'b100; step("R6");
    clear(); fetch_addr = 32'h308; setb(11, 2'd1); step("R7");
    clear(); fetch_addr = 32'h308; setb(5, 2'd2); step("R7");
    clear(); fetch_addr = 32'h300; ras_top = 32'hABC0; setb(13, 2'd3); step("R8");
    clear(); fetch_addr = 32'h30C; setb(1, 2'd0); setb(4, 2'd0); setb(7, 2'd0);
    setb(9, 2'd0); setb(12, 2'd0); step("R9");
    clear(); fetch_addr = 32'h400; setb(0, 2'd0); setb(1, 2'd0); setb(2, 2'd0); setb(3, 2'd0);
    step("R9");
    clear(); fetch_addr = 32'h500; setb(2, 2'd1); line_hit = 2'b10; step("R2");
    clear(); fetch_addr = 32'h504; line_hit = 2'b01; step("R2");
    clear(); fetch_addr = 32'h504; line_hit = 2'b00; step("R2");

    for (int n = 0; n < 400; n++) begin
      fetch_addr = $urandom & 32'hFFFF_FFFC;
      line_hit = ($urandom % 8 == 0) ? 2'($urandom) : 2'b11;
      btb_valid = 16'($urandom) & 16'($urandom);
      btb_kind = $urandom;
      for (int i = 0; i < 16; i++) btb_target[32*i +: 32] = $urandom & 32'hFFFF_FFFC;
      pred_taken = 3'($urandom) & 3'($urandom);
      ras_top = $urandom & 32'hFFFF_FFFC;
      step("R1");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule